// File: doc/BRIEF.md
# Program Word Exchange Path

This block sits between a 24-bit-wide program memory port and a 16-bit register file. A 24-bit word read from program memory is split in two. The upper sixteen bits go to the destination register. The low eight bits are kept in a hidden 8-bit exchange register. When a word is written back, the 16-bit source register supplies the upper sixteen bits and the exchange register supplies the low byte. A full 24-bit word can therefore be copied from one location to another with one read and one write, even though only 16 bits pass through the register file.

Software can also load the exchange register from a data register and read it back, which lets a program build or inspect the low byte on its own. When an access targets 16-bit-wide memory, the word is carried in the low sixteen bits and the exchange register is cleared. Address generation and the memory array are outside this block.

Top module: `pbx_exchange_path`

## Requirements
- R1: After synchronous reset the exchange register holds zero, so `xr_value` reads 0.
- R2: For a wide read, `dst_data` equals `rd_data[23:8]` in the same cycle (combinational path).
- R3: A wide read with `rd_valid` high loads `rd_data[7:0]` into the exchange register at the next rising edge.
- R4: A narrow read (`rd_narrow`=1) drives `rd_data[15:0]` on `dst_data` and clears the exchange register at the next edge.
- R5: For a wide write, `wr_data` equals `{wr_src, exchange register}`, with `wr_src` in bits 23:8.
- R6: For a narrow write (`wr_narrow`=1), `wr_data` equals `{8'h00, wr_src}`.
- R7: A direct load (`xr_load`=1 with no read in the same cycle) stores `xr_load_data[7:0]` at the next edge and ignores the upper byte.
- R8: `xr_value` shows the exchange register zero-extended to 16 bits.
- R9: If a read capture and a direct load occur in the same cycle, the value from the read capture is stored.
- R10: With neither `rd_valid` nor `xr_load` high, the exchange register keeps its value.
- R11: A wide read followed, one cycle later or more, by a wide write with `wr_src` equal to the `dst_data` just read reproduces the original 24-bit word on `wr_data`.
- R12: In a cycle that both writes and captures, `wr_data` uses the exchange register value from before that capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Program memory read data is present this cycle |
| rd_narrow | input | 1 | The read targets 16-bit-wide memory |
| rd_data | input | 24 | Word returned by program memory |
| dst_data | output | 16 | Value for the destination data register |
| wr_narrow | input | 1 | The write targets 16-bit-wide memory |
| wr_src | input | 16 | Source data register for a write |
| wr_data | output | 24 | Word presented to program memory |
| xr_load | input | 1 | Direct load of the exchange register |
| xr_load_data | input | 16 | Data register value for the direct load |
| xr_value | output | 16 | Exchange register, zero-extended |

## Verification
The hardest case to reach is a single cycle in which a read capture, a direct load and a write all happen together. In that cycle the write must use the old low byte, while the capture must win over the load at the edge. Random stimulus with a fixed seed drives all three controls independently and at high density, so such collisions happen often. A directed sequence also forces the collision and then checks the stored byte in the following cycle. A directed read-then-write copy confirms that a full word survives the 16-bit path.

// File: rtl/pbx_pkg.sv
package pbx_pkg;

    localparam int WORD_W = 24;
    localparam int REG_W  = 16;
    localparam int XR_W   = WORD_W - REG_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [REG_W-1:0]  reg_t;
    typedef logic [XR_W-1:0]   xr_t;

    typedef struct packed {
        logic  valid;
        logic  narrow;
        word_t data;
    } rd_beat_t;

    typedef struct packed {
        reg_t hi;
        xr_t  lo;
    } split_t;

    typedef enum logic [1:0] {
        XR_HOLD    = 2'd0,
        XR_CAPTURE = 2'd1,
        XR_LOAD    = 2'd2
    } xr_sel_e;

    function automatic split_t split_word(input word_t w, input logic narrow);
        split_t s;
        if (narrow) begin
            s.hi = w[REG_W-1:0];
            s.lo = '0;
        end else begin
            s.hi = w[WORD_W-1:XR_W];
            s.lo = w[XR_W-1:0];
        end
        return s;
    endfunction

    function automatic word_t merge_word(input reg_t src, input xr_t xr, input logic narrow);
        word_t w;
        if (narrow) w = {{(WORD_W-REG_W){1'b0}}, src};
        else        w = {src, xr};
        return w;
    endfunction

    function automatic reg_t zext_xr(input xr_t x);
        return {{(REG_W-XR_W){1'b0}}, x};
    endfunction

endpackage

// File: rtl/pbx_read_split.sv
module pbx_read_split
    import pbx_pkg::*;
(
    input  rd_beat_t beat,
    output reg_t     dst,
    output logic     cap_en,
    output xr_t      cap_val
);
    split_t parts;

    always_comb begin
        parts   = split_word(beat.data, beat.narrow);
        dst     = parts.hi;
        cap_en  = beat.valid;
        cap_val = parts.lo;
    end
endmodule

// File: rtl/pbx_xreg.sv
module pbx_xreg
    import pbx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cap_en,
    input  xr_t  cap_val,
    input  logic ld_en,
    input  xr_t  ld_val,
    output xr_t  xr_q
);
    xr_sel_e sel;

    always_comb begin
        if (cap_en)     sel = XR_CAPTURE;
        else if (ld_en) sel = XR_LOAD;
        else            sel = XR_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xr_q <= '0;
        end else begin
            case (sel)
                XR_CAPTURE: xr_q <= cap_val;
                XR_LOAD:    xr_q <= ld_val;
                default:    xr_q <= xr_q;
            endcase
        end
    end

    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (rst)
        (cap_en && ld_en) |=> (xr_q == $past(cap_val))) else $error("capture priority"); // R9
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        (ld_en && !cap_en) |=> (xr_q == $past(ld_val))) else $error("direct load"); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && !cap_en) |=> $stable(xr_q)) else $error("hold"); // R10
endmodule

// File: rtl/pbx_write_merge.sv
module pbx_write_merge
    import pbx_pkg::*;
(
    input  reg_t  src,
    input  xr_t   xr,
    input  logic  narrow,
    output word_t word
);
    always_comb word = merge_word(src, xr, narrow);
endmodule

// File: rtl/pbx_exchange_path.sv
module pbx_exchange_path
    import pbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_valid,
    input  logic              rd_narrow,
    input  logic [WORD_W-1:0] rd_data,
    output logic [REG_W-1:0]  dst_data,
    input  logic              wr_narrow,
    input  logic [REG_W-1:0]  wr_src,
    output logic [WORD_W-1:0] wr_data,
    input  logic              xr_load,
    input  logic [REG_W-1:0]  xr_load_data,
    output logic [REG_W-1:0]  xr_value
);
    rd_beat_t beat;
    logic     cap_en;
    xr_t      cap_val;
    xr_t      xr_q;

    always_comb begin
        beat.valid  = rd_valid;
        beat.narrow = rd_narrow;
        beat.data   = rd_data;
    end

    pbx_read_split u_split (
        .beat    (beat),
        .dst     (dst_data),
        .cap_en  (cap_en),
        .cap_val (cap_val)
    );

    pbx_xreg u_xreg (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .cap_val (cap_val),
        .ld_en   (xr_load),
        .ld_val  (xr_load_data[XR_W-1:0]),
        .xr_q    (xr_q)
    );

    pbx_write_merge u_merge (
        .src    (wr_src),
        .xr     (xr_q),
        .narrow (wr_narrow),
        .word   (wr_data)
    );

    assign xr_value = zext_xr(xr_q);

    AST_WIDE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_narrow) |=> (xr_value[XR_W-1:0] == $past(rd_data[XR_W-1:0]))) else $error("wide capture"); // R3
    AST_NARROW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_narrow) |=> (xr_value == '0)) else $error("narrow clear"); // R4
    AST_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        (xr_value[REG_W-1:XR_W] == '0)) else $error("zero extension"); // R8
    AST_WIDE_LOW_BYTE: assert property (@(posedge clk) disable iff (rst)
        !wr_narrow |-> (wr_data[XR_W-1:0] == xr_value[XR_W-1:0])) else $error("write low byte"); // R5
endmodule

// File: tb/pbx_exchange_path_tb.sv
module pbx_exchange_path_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_valid = 1'b0, rd_narrow = 1'b0;
    logic [23:0] rd_data = '0;
    logic [15:0] dst_data;
    logic        wr_narrow = 1'b0;
    logic [15:0] wr_src = '0;
    logic [23:0] wr_data;
    logic        xr_load = 1'b0;
    logic [15:0] xr_load_data = '0;
    logic [15:0] xr_value;

    int checks = 0;
    int errors = 0;
    logic [7:0] model_xr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbx_exchange_path u_dut (
        .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_narrow(rd_narrow),
        .rd_data(rd_data), .dst_data(dst_data), .wr_narrow(wr_narrow),
        .wr_src(wr_src), .wr_data(wr_data), .xr_load(xr_load),
        .xr_load_data(xr_load_data), .xr_value(xr_value)
    );

    function automatic logic [15:0] exp_dst(input logic [23:0] d, input logic n);
        return n ? d[15:0] : d[23:8];
    endfunction

    function automatic logic [23:0] exp_wr(input logic [15:0] s, input logic [7:0] x, input logic n);
        return n ? {8'h00, s} : {s, x};
    endfunction

    function automatic logic [7:0] next_xr(input logic [7:0] cur, input logic rv, input logic rn,
                                           input logic [23:0] d, input logic ld, input logic [15:0] ldd);
        if (rv) return rn ? 8'h00 : d[7:0];
        if (ld) return ldd[7:0];
        return cur;
    endfunction

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle's inputs after a falling edge, check outputs, then step the model at the rising edge.
    task automatic cycle(input logic rv, input logic rn, input logic [23:0] d,
                         input logic wn, input logic [15:0] s,
                         input logic ld, input logic [15:0] ldd);
        rd_valid = rv; rd_narrow = rn; rd_data = d;
        wr_narrow = wn; wr_src = s; xr_load = ld; xr_load_data = ldd;
        #1;
        if (rv) chk(rn ? "R4 narrow dst" : "R2 wide dst", {8'h00, dst_data}, {8'h00, exp_dst(d, rn)});
        chk(wn ? "R6 narrow write" : "R5/R12 wide write", wr_data, exp_wr(s, model_xr, wn));
        chk("R8 readback", {8'h00, xr_value}, {16'h0000, model_xr});
        @(posedge clk);
        model_xr = next_xr(model_xr, rv, rn, d, ld, ldd);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] held;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset value", {8'h00, xr_value}, 24'h0);

        // R3: wide capture, then R11 copy via the following write
        cycle(1'b1, 1'b0, 24'hABCD5A, 1'b0, 16'h0000, 1'b0, 16'h0);
        held = 16'hABCD;
        chk("R3 capture", {8'h00, xr_value}, 24'h00005A);
        cycle(1'b0, 1'b0, 24'h0, 1'b0, held, 1'b0, 16'h0);
        chk("R11 copy", {held, xr_value[7:0]}, 24'hABCD5A);

        // R7: load keeps only the low byte
        cycle(1'b0, 1'b0, 24'h0, 1'b0, 16'h0, 1'b1, 16'hFF3C);
        chk("R7 load low byte", {8'h00, xr_value}, 24'h00003C);

        // R10: idle holds
        cycle(1'b0, 1'b0, 24'h0, 1'b1, 16'h1234, 1'b0, 16'h0);
        chk("R10 hold", {8'h00, xr_value}, 24'h00003C);

        // R9 and R12: capture, load and write together
        cycle(1'b1, 1'b0, 24'h123477, 1'b0, 16'hBEEF, 1'b1, 16'h0099);
        chk("R9 capture wins", {8'h00, xr_value}, 24'h000077);

        // R4: narrow read clears
        cycle(1'b1, 1'b1, 24'hFF8001, 1'b0, 16'h0, 1'b1, 16'h00AA);
        chk("R4 narrow clear", {8'h00, xr_value}, 24'h0);

        // reset again mid-run for R1
        cycle(1'b0, 1'b0, 24'h0, 1'b0, 16'h0, 1'b1, 16'h00EE);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        model_xr = 8'h00;
        #1;
        chk("R1 reset after load", {8'h00, xr_value}, 24'h0);

        for (int i = 0; i < 400; i++) begin
            cycle($urandom_range(0, 1), ($urandom_range(0, 3) == 0), 24'($urandom),
                  ($urandom_range(0, 3) == 0), 16'($urandom),
                  $urandom_range(0, 1), 16'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule